// File: doc/BRIEF.md
# Complementary PWM dead-time counter unit

This block is the counting core of a complementary PWM timer. Two phase counters trace the same triangular carrier, from zero up to the sum of the period and dead-time settings and back. They are kept apart by a programmable dead-time offset. A third counter, the carrier-sync counter, runs inside the band that the dead time adds above the period setting. It counts down, turns upward when it meets the period value, and turns down again at the peak.

Each phase counter drives one complementary output pair against a shared compare value. The positive output is high while the counter is above the compare value. The negative output is high while the counter plus the dead time is still below it. In the band between, both outputs are low, and this gap is the inserted dead time. Software sets the dead-time and period values through a 16-bit write port with byte enables. Only whole-word writes are accepted.

Three reset sources act on the block:
- A power-on reset returns everything to its initial state.
- Standby entry returns everything to its initial state.
- A manual reset stops and clears the counters but keeps the programmed settings.

Top module: `cpwm_deadtime_unit`

## Requirements
- R1: A power-on reset (por_n low) sets both the dead-time and the period register to 0xFFFF. Holding standby high for a clock edge does the same, and also clears acc_err, stops the counters and clears them.
- R2: A clock edge with man_rst_n low leaves both registers unchanged. It clears all three counters to 0, stops counting and drives all outputs low. Phase counters then face upward and the carrier counter faces downward.
- R3: A write (wr_en high) with wr_be == 2'b11 stores wr_data at the next edge. wr_sel 0 selects the dead-time register and wr_sel 1 selects the period register. A write with any other wr_be value changes neither register.
- R4: acc_err is high for exactly the cycle after an edge at which a write with wr_be != 2'b11 was presented. Otherwise it is low.
- R5: An edge with mode_en and restart both high (and no manual reset or standby) starts counting. The lead phase counter (phase_a_cnt) is loaded with the dead-time value and the lag phase counter (phase_b_cnt) with 0, both facing upward. The carrier counter is loaded with period + dead time and faces downward.
- R6: While counting and mode_en is high, each phase counter steps by one per edge between 0 and period + dead time. It reverses at either end: it turns down at the top value and up at 0. It stays at 0 when that top value is 0.
- R7: While counting and mode_en is high, the carrier counter steps by one per edge. It decrements until it equals the period value, then increments, and turns down again at period + dead time. carrier_rising is 1 while it faces upward. It holds when the dead time is 0.
- R8: While counting and mode_en is high, pwm_x_p = (counter > cmp_val) and pwm_x_n = (counter + dead time < cmp_val) for each pair x. The two outputs of a pair are never high together.
- R9: With mode_en low, all counters hold their values, restart has no effect and all four PWM outputs are low. Counting resumes from the held values when mode_en returns high.
- R10: rd_data shows the dead-time register when rd_sel is 0 and the period register when rd_sel is 1, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| man_rst_n | input | 1 | Synchronous manual reset, active low, keeps registers |
| standby | input | 1 | Synchronous standby entry, reinitialises registers |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 dead time, 1 period |
| wr_be | input | 2 | Byte enables, 2'b11 required |
| wr_data | input | 16 | Write data |
| acc_err | output | 1 | One-cycle flag for a rejected partial write |
| rd_sel | input | 1 | Read target: 0 dead time, 1 period |
| rd_data | output | 16 | Selected register value |
| mode_en | input | 1 | Complementary mode enable |
| restart | input | 1 | Clear and restart pulse |
| cmp_val | input | 16 | Compare value shared by both pairs |
| phase_a_cnt | output | 17 | Lead phase counter |
| phase_b_cnt | output | 17 | Lag phase counter |
| carrier_cnt | output | 17 | Carrier-sync counter |
| carrier_rising | output | 1 | Carrier counter direction, 1 = up |
| pwm_a_p | output | 1 | Lead pair positive output |
| pwm_a_n | output | 1 | Lead pair negative output |
| pwm_b_p | output | 1 | Lag pair positive output |
| pwm_b_n | output | 1 | Lag pair negative output |

## Verification
The range and turnaround assertions on the counters assume that the dead-time and period registers are only rewritten while the counters are stopped. That is, a whole-word write lands only before the first restart or after a manual reset or standby, never while counting. The stimulus obeys this. Every register update is placed right after a manual reset, and the random part only issues rejected partial writes while counting. The compare value, mode toggles and restart pulses may change freely in any cycle, because the design treats them as live inputs.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic {
    SEL_DEAD   = 1'b0,
    SEL_PERIOD = 1'b1
  } cpwm_sel_e;

  typedef struct packed {
    logic        rising;
    logic [31:0] cnt;
  } step_t;

  // Triangle between 0 and top; reverses at either end.
  function automatic step_t phase_step(input logic [31:0] cnt,
                                       input logic        rising,
                                       input logic [31:0] top);
    step_t s;
    s.rising = rising;
    s.cnt    = cnt;
    if (top == 32'd0) begin
      s.rising = 1'b1;
      s.cnt    = 32'd0;
    end else if (rising) begin
      if (cnt >= top) begin
        s.rising = 1'b0;
        s.cnt    = cnt - 32'd1;
      end else begin
        s.cnt = cnt + 32'd1;
      end
    end else begin
      if (cnt == 32'd0) begin
        s.rising = 1'b1;
        s.cnt    = 32'd1;
      end else begin
        s.cnt = cnt - 32'd1;
      end
    end
    return s;
  endfunction

  // Carrier band: falls to floor_v, turns up there, turns down at top.
  function automatic step_t carrier_step(input logic [31:0] cnt,
                                         input logic        rising,
                                         input logic [31:0] floor_v,
                                         input logic [31:0] top);
    step_t s;
    s.rising = rising;
    s.cnt    = cnt;
    if (top <= floor_v) begin
      s.cnt = cnt;
    end else if (!rising) begin
      if (cnt <= floor_v) begin
        s.rising = 1'b1;
        s.cnt    = cnt + 32'd1;
      end else begin
        s.cnt = cnt - 32'd1;
      end
    end else begin
      if (cnt >= top) begin
        s.rising = 1'b0;
        s.cnt    = cnt - 32'd1;
      end else begin
        s.cnt = cnt + 32'd1;
      end
    end
    return s;
  endfunction

  function automatic logic is_above(input logic [31:0] cnt, input logic [31:0] cmp);
    return cnt > cmp;
  endfunction

  function automatic logic is_below_gap(input logic [31:0] cnt, input logic [31:0] dt,
                                        input logic [31:0] cmp);
    return (cnt + dt) < cmp;
  endfunction

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           standby,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [W/8-1:0] wr_be,
  input  logic [W-1:0]   wr_data,
  output logic [W-1:0]   dt_o,
  output logic [W-1:0]   per_o,
  output logic           acc_err_o
);
  import cpwm_pkg::*;

  localparam int              BE_W    = W / 8;
  localparam logic [BE_W-1:0] BE_FULL = '1;

  logic full_wr;
  logic part_wr;
  assign full_wr = wr_en && (wr_be == BE_FULL);
  assign part_wr = wr_en && (wr_be != BE_FULL);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dt_o      <= '1;
      per_o     <= '1;
      acc_err_o <= 1'b0;
    end else if (standby) begin
      dt_o      <= '1;
      per_o     <= '1;
      acc_err_o <= 1'b0;
    end else begin
      if (full_wr && (wr_sel == SEL_DEAD))   dt_o  <= wr_data;
      if (full_wr && (wr_sel == SEL_PERIOD)) per_o <= wr_data;
      acc_err_o <= part_wr;
    end
  end

  a_r1_standby_init: assert property (@(posedge clk) disable iff (!por_n)
    standby |=> (dt_o == '1 && per_o == '1 && !acc_err_o));

  a_r3_partial_ignored: assert property (@(posedge clk) disable iff (!por_n)
    (part_wr && !standby) |=> ($stable(dt_o) && $stable(per_o)));

  a_r4_err_raised: assert property (@(posedge clk) disable iff (!por_n)
    (part_wr && !standby) |=> acc_err_o);

  a_r4_err_quiet: assert property (@(posedge clk) disable iff (!por_n)
    !wr_en |=> !acc_err_o);

endmodule

// File: rtl/cpwm_updown.sv
module cpwm_updown #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          clr,
  input  logic          load,
  input  logic          step_en,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] cnt_o
);
  import cpwm_pkg::*;

  logic  rising;
  step_t nxt;

  always_comb nxt = phase_step(32'(cnt_o), rising, 32'(top));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_o  <= '0;
      rising <= 1'b1;
    end else if (clr) begin
      cnt_o  <= '0;
      rising <= 1'b1;
    end else if (load) begin
      cnt_o  <= load_val;
      rising <= 1'b1;
    end else if (step_en) begin
      cnt_o  <= CW'(nxt.cnt);
      rising <= nxt.rising;
    end
  end

  // R6: never leaves 0..top while stepping (registers stable while running)
  a_r6_in_range: assert property (@(posedge clk) disable iff (!por_n)
    (step_en && !clr && !load && cnt_o <= top) |=> (cnt_o <= top));

  a_r9_hold: assert property (@(posedge clk) disable iff (!por_n)
    (!step_en && !clr && !load) |=> $stable(cnt_o));

endmodule

// File: rtl/cpwm_carrier.sv
module cpwm_carrier #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          clr,
  input  logic          load,
  input  logic          step_en,
  input  logic [CW-1:0] floor_v,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] cnt_o,
  output logic          rising_o
);
  import cpwm_pkg::*;

  step_t nxt;
  logic  hit_floor;

  always_comb nxt = carrier_step(32'(cnt_o), rising_o, 32'(floor_v), 32'(top));
  assign hit_floor = !rising_o && (cnt_o == floor_v) && (top != floor_v);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_o    <= '0;
      rising_o <= 1'b0;
    end else if (clr) begin
      cnt_o    <= '0;
      rising_o <= 1'b0;
    end else if (load) begin
      cnt_o    <= top;
      rising_o <= 1'b0;
    end else if (step_en) begin
      cnt_o    <= CW'(nxt.cnt);
      rising_o <= nxt.rising;
    end
  end

  a_r7_turn_up: assert property (@(posedge clk) disable iff (!por_n)
    (step_en && !clr && !load && hit_floor) |=> (rising_o && cnt_o == $past(floor_v) + 1'b1));

  a_r7_in_band: assert property (@(posedge clk) disable iff (!por_n)
    (step_en && !clr && !load && cnt_o >= floor_v && cnt_o <= top)
      |=> (cnt_o >= floor_v && cnt_o <= top));

endmodule

// File: rtl/cpwm_out_pair.sv
module cpwm_out_pair #(
  parameter int W  = 16,
  parameter int CW = 17
) (
  input  logic          active,
  input  logic [CW-1:0] cnt,
  input  logic [W-1:0]  cmp,
  input  logic [W-1:0]  dt,
  output logic          out_p,
  output logic          out_n
);
  import cpwm_pkg::*;

  always_comb begin
    out_p = active && is_above(32'(cnt), 32'(cmp));
    out_n = active && is_below_gap(32'(cnt), 32'(dt), 32'(cmp));
    a_r8_exclusive: assert (!(out_p && out_n))
      else $error("pair outputs both high");
  end

endmodule

// File: rtl/cpwm_deadtime_unit.sv
module cpwm_deadtime_unit #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           man_rst_n,
  input  logic           standby,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [W/8-1:0] wr_be,
  input  logic [W-1:0]   wr_data,
  output logic           acc_err,
  input  logic           rd_sel,
  output logic [W-1:0]   rd_data,
  input  logic           mode_en,
  input  logic           restart,
  input  logic [W-1:0]   cmp_val,
  output logic [W:0]     phase_a_cnt,
  output logic [W:0]     phase_b_cnt,
  output logic [W:0]     carrier_cnt,
  output logic           carrier_rising,
  output logic           pwm_a_p,
  output logic           pwm_a_n,
  output logic           pwm_b_p,
  output logic           pwm_b_n
);
  import cpwm_pkg::*;

  localparam int CW     = W + 1;
  localparam int PHASES = 2;

  logic [W-1:0]  dt_q;
  logic [W-1:0]  per_q;
  logic [CW-1:0] dt_ext;
  logic [CW-1:0] per_ext;
  logic [CW-1:0] top_val;
  logic          running;
  logic          clr_evt;
  logic          restart_take;
  logic          step_en;
  logic          out_active;
  logic [CW-1:0] ph_cnt [PHASES];
  logic          ph_p   [PHASES];
  logic          ph_n   [PHASES];

  assign dt_ext       = {1'b0, dt_q};
  assign per_ext      = {1'b0, per_q};
  assign top_val      = dt_ext + per_ext;
  assign clr_evt      = !man_rst_n || standby;
  assign restart_take = mode_en && restart && !clr_evt;
  assign step_en      = running && mode_en;
  assign out_active   = running && mode_en;

  cpwm_regs #(.W(W)) u_regs (
    .clk       (clk),
    .por_n     (por_n),
    .standby   (standby),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_be     (wr_be),
    .wr_data   (wr_data),
    .dt_o      (dt_q),
    .per_o     (per_q),
    .acc_err_o (acc_err)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            running <= 1'b0;
    else if (clr_evt)      running <= 1'b0;
    else if (restart_take) running <= 1'b1;
  end

  for (genvar i = 0; i < PHASES; i++) begin : g_ph
    logic [CW-1:0] ld_v;
    if (i == 0) begin : g_lead
      assign ld_v = dt_ext;
    end else begin : g_lag
      assign ld_v = '0;
    end

    cpwm_updown #(.CW(CW)) u_ctr (
      .clk      (clk),
      .por_n    (por_n),
      .clr      (clr_evt),
      .load     (restart_take),
      .step_en  (step_en),
      .load_val (ld_v),
      .top      (top_val),
      .cnt_o    (ph_cnt[i])
    );

    cpwm_out_pair #(.W(W), .CW(CW)) u_pair (
      .active (out_active),
      .cnt    (ph_cnt[i]),
      .cmp    (cmp_val),
      .dt     (dt_q),
      .out_p  (ph_p[i]),
      .out_n  (ph_n[i])
    );
  end

  cpwm_carrier #(.CW(CW)) u_carrier (
    .clk      (clk),
    .por_n    (por_n),
    .clr      (clr_evt),
    .load     (restart_take),
    .step_en  (step_en),
    .floor_v  (per_ext),
    .top      (top_val),
    .cnt_o    (carrier_cnt),
    .rising_o (carrier_rising)
  );

  assign phase_a_cnt = ph_cnt[0];
  assign phase_b_cnt = ph_cnt[1];
  assign pwm_a_p     = ph_p[0];
  assign pwm_a_n     = ph_n[0];
  assign pwm_b_p     = ph_p[1];
  assign pwm_b_n     = ph_n[1];
  assign rd_data     = (rd_sel == SEL_PERIOD) ? per_q : dt_q;

  a_r5_offset_load: assert property (@(posedge clk) disable iff (!por_n)
    restart_take |=> (phase_a_cnt == $past(dt_ext) && phase_b_cnt == '0
                      && carrier_cnt == $past(top_val) && !carrier_rising));

  a_r2_regs_kept: assert property (@(posedge clk) disable iff (!por_n)
    (!man_rst_n && !wr_en && !standby) |=> ($stable(dt_q) && $stable(per_q)));

  a_r2_stopped: assert property (@(posedge clk) disable iff (!por_n)
    !man_rst_n |=> (!running && phase_a_cnt == '0 && carrier_cnt == '0));

  a_r9_outputs_idle: assert property (@(posedge clk) disable iff (!por_n)
    !mode_en |-> !(pwm_a_p || pwm_a_n || pwm_b_p || pwm_b_n));

endmodule

// File: tb/tb_cpwm_deadtime_unit.sv
`timescale 1ns/1ps
module tb_cpwm_deadtime_unit;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        man_rst_n = 1'b1;
  logic        standby = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = '0;
  logic        acc_err;
  logic        rd_sel = 1'b0;
  logic [15:0] rd_data;
  logic        mode_en = 1'b0;
  logic        restart = 1'b0;
  logic [15:0] cmp_val = '0;
  logic [16:0] phase_a_cnt;
  logic [16:0] phase_b_cnt;
  logic [16:0] carrier_cnt;
  logic        carrier_rising;
  logic        pwm_a_p;
  logic        pwm_a_n;
  logic        pwm_b_p;
  logic        pwm_b_n;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  cpwm_deadtime_unit dut (
    .clk(clk), .por_n(por_n), .man_rst_n(man_rst_n), .standby(standby),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be), .wr_data(wr_data),
    .acc_err(acc_err), .rd_sel(rd_sel), .rd_data(rd_data),
    .mode_en(mode_en), .restart(restart), .cmp_val(cmp_val),
    .phase_a_cnt(phase_a_cnt), .phase_b_cnt(phase_b_cnt),
    .carrier_cnt(carrier_cnt), .carrier_rising(carrier_rising),
    .pwm_a_p(pwm_a_p), .pwm_a_n(pwm_a_n), .pwm_b_p(pwm_b_p), .pwm_b_n(pwm_b_n)
  );

  // ---------------- reference state, built from the requirements ----------
  int unsigned m_dt, m_per, m_a, m_b, m_c;
  bit          m_err, m_run, m_au, m_bu, m_cu;

  function automatic int unsigned tri_next(int unsigned c, bit up, int unsigned top,
                                           output bit up_o);
    if (top == 0) begin up_o = 1'b1; return 0; end
    if (up && c < top) begin up_o = 1'b1; return c + 1; end
    if (!up && c > 0) begin up_o = 1'b0; return c - 1; end
    up_o = !up;
    return up ? c - 1 : c + 1;
  endfunction

  function automatic int unsigned band_next(int unsigned c, bit up, int unsigned lo,
                                            int unsigned hi, output bit up_o);
    if (hi == lo) begin up_o = up; return c; end
    if (!up && c > lo) begin up_o = 1'b0; return c - 1; end
    if (up && c < hi) begin up_o = 1'b1; return c + 1; end
    up_o = !up;
    return up ? c - 1 : c + 1;
  endfunction

  task automatic model_reset_counters();
    m_run = 0; m_a = 0; m_b = 0; m_c = 0; m_au = 1; m_bu = 1; m_cu = 0;
  endtask

  task automatic model_tick();
    int unsigned top;
    bit          nu;
    if (!por_n) begin
      m_dt = 16'hFFFF; m_per = 16'hFFFF; m_err = 0;
      model_reset_counters();
      return;
    end
    top = m_dt + m_per;
    if (!man_rst_n || standby) model_reset_counters();
    else if (mode_en && restart) begin
      m_a = m_dt; m_au = 1; m_b = 0; m_bu = 1; m_c = top; m_cu = 0; m_run = 1;
    end else if (m_run && mode_en) begin
      m_a = tri_next(m_a, m_au, top, nu); m_au = nu;
      m_b = tri_next(m_b, m_bu, top, nu); m_bu = nu;
      m_c = band_next(m_c, m_cu, m_per, top, nu); m_cu = nu;
    end
    if (standby) begin
      m_dt = 16'hFFFF; m_per = 16'hFFFF; m_err = 0;
    end else begin
      if (wr_en && wr_be == 2'b11) begin
        if (wr_sel) m_per = wr_data; else m_dt = wr_data;
      end
      m_err = wr_en && (wr_be != 2'b11);
    end
  endtask

  always @(posedge clk) model_tick();

  initial begin
    m_dt = 16'hFFFF; m_per = 16'hFFFF; m_err = 0;
    model_reset_counters();
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, int unsigned act, int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    bit act;
    act = m_run && mode_en;
    chk("R6 lead phase counter", phase_a_cnt, m_a);
    chk("R6 lag phase counter", phase_b_cnt, m_b);
    chk("R7 carrier counter", carrier_cnt, m_c);
    chk("R7 carrier direction", carrier_rising, m_cu);
    chk("R8 lead p", pwm_a_p, act && (m_a > cmp_val));
    chk("R8 lead n", pwm_a_n, act && (m_a + m_dt < cmp_val));
    chk("R8 lag p", pwm_b_p, act && (m_b > cmp_val));
    chk("R8 lag n", pwm_b_n, act && (m_b + m_dt < cmp_val));
    chk("R4 access error flag", acc_err, m_err);
    chk("R10 read data", rd_data, rd_sel ? m_per : m_dt);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(bit sel, logic [1:0] be, logic [15:0] d);
    wr_en = 1; wr_sel = sel; wr_be = be; wr_data = d;
    tick();
    wr_en = 0; wr_be = 2'b00;
  endtask

  task automatic pulse_man_rst();
    man_rst_n = 0; tick(); man_rst_n = 1;
  endtask

  task automatic do_restart();
    restart = 1; tick(); restart = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [16:0] hold_a, hold_c;
    void'($urandom(32'd20240611));
    por_n = 0;
    repeat (3) tick();
    por_n = 1;
    tick();
    // R1: reset values
    rd_sel = 0; tick(); chk("R1 dead-time after power-on", rd_data, 16'hFFFF);
    rd_sel = 1; tick(); chk("R1 period after power-on", rd_data, 16'hFFFF);
    chk("R1 lead counter after power-on", phase_a_cnt, 0);
    chk("R1 outputs low", {pwm_a_p, pwm_a_n, pwm_b_p, pwm_b_n}, 0);

    // R3/R4: partial writes rejected
    wr(1'b0, 2'b01, 16'h0007);
    chk("R4 flag after low-byte write", acc_err, 1);
    rd_sel = 0; tick();
    chk("R4 flag clears", acc_err, 0);
    chk("R3 dead-time unchanged by byte write", rd_data, 16'hFFFF);
    wr(1'b1, 2'b10, 16'h0100);
    chk("R4 flag after high-byte write", acc_err, 1);
    rd_sel = 1; tick();
    chk("R3 period unchanged by byte write", rd_data, 16'hFFFF);

    // R3/R10: full writes
    wr(1'b0, 2'b11, 16'd5);
    wr(1'b1, 2'b11, 16'd20);
    rd_sel = 0; tick(); chk("R10 dead-time readback", rd_data, 5);
    rd_sel = 1; tick(); chk("R10 period readback", rd_data, 20);

    // R5: restart
    mode_en = 1; cmp_val = 16'd12;
    do_restart();
    chk("R5 lead counter loaded with dead time", phase_a_cnt, 5);
    chk("R5 lag counter loaded with zero", phase_b_cnt, 0);
    chk("R5 carrier loaded with peak", carrier_cnt, 25);
    chk("R5 carrier faces down", carrier_rising, 0);
    tick();
    chk("R5 counters separated by dead time", phase_a_cnt - phase_b_cnt, 5);
    for (int i = 0; i < 120; i++) begin
      if (i % 17 == 0) cmp_val = 16'($urandom_range(0, 30));
      tick();
    end

    // R9: mode off holds
    mode_en = 0; tick();
    hold_a = phase_a_cnt; hold_c = carrier_cnt;
    restart = 1; tick(); restart = 0;
    repeat (5) tick();
    chk("R9 lead counter held", phase_a_cnt, hold_a);
    chk("R9 carrier held, restart ignored", carrier_cnt, hold_c);
    chk("R9 outputs low", {pwm_a_p, pwm_a_n, pwm_b_p, pwm_b_n}, 0);
    mode_en = 1; repeat (10) tick();

    // R2: manual reset keeps registers
    pulse_man_rst();
    chk("R2 counters cleared", phase_a_cnt + phase_b_cnt + carrier_cnt, 0);
    rd_sel = 0; tick(); chk("R2 dead-time kept", rd_data, 5);
    rd_sel = 1; tick(); chk("R2 period kept", rd_data, 20);
    chk("R2 outputs low while stopped", {pwm_a_p, pwm_a_n, pwm_b_p, pwm_b_n}, 0);

    // R1: standby reinitialises
    do_restart(); repeat (4) tick();
    wr(1'b0, 2'b10, 16'h0);
    standby = 1; tick(); standby = 0;
    chk("R1 standby clears flag", acc_err, 0);
    chk("R1 standby stops counters", phase_a_cnt, 0);
    rd_sel = 0; tick(); chk("R1 dead-time after standby", rd_data, 16'hFFFF);
    rd_sel = 1; tick(); chk("R1 period after standby", rd_data, 16'hFFFF);

    // R6/R7 edge: zero dead time and zero period
    pulse_man_rst();
    wr(1'b0, 2'b11, 16'd0); wr(1'b1, 2'b11, 16'd0);
    do_restart(); repeat (6) tick();
    chk("R6 zero top holds at zero", phase_a_cnt, 0);
    chk("R7 zero dead time holds carrier", carrier_cnt, 0);

    // Random runs
    for (int r = 0; r < 24; r++) begin
      pulse_man_rst();
      wr(1'b0, 2'b11, 16'($urandom_range(0, 15)));
      wr(1'b1, 2'b11, 16'($urandom_range(0, 40)));
      rd_sel = $urandom_range(0, 1);
      mode_en = 1;
      do_restart();
      for (int k = 0; k < int'($urandom_range(60, 150)); k++) begin
        if ($urandom_range(0, 9) == 0) cmp_val = 16'($urandom_range(0, 60));
        if ($urandom_range(0, 19) == 0) mode_en = !mode_en;
        if ($urandom_range(0, 39) == 0) restart = 1;
        if ($urandom_range(0, 29) == 0) begin
          wr_en = 1; wr_sel = $urandom_range(0, 1);
          wr_be = ($urandom_range(0, 1) != 0) ? 2'b01 : 2'b10;
          wr_data = 16'($urandom);
        end
        tick();
        restart = 0; wr_en = 0; wr_be = 2'b00;
      end
    end

    summary();
    $finish;
  end

endmodule